// File: doc/BRIEF.md
# Predicated SIMD Line Array

This block is an array of small processing elements that all run the same instruction in the same cycle. Each element owns a private memory of 16-bit words. A word address selects a "line": the word at that address in every element at once. The controller issues one instruction per cycle. An instruction names a destination line and a first source line. Its second operand is either another line or a scalar that the controller sends once and every element uses. The arithmetic results are written back to the destination line in every element that takes part.

Each element also holds an activity flag. Compare instructions compute the flag from the element's own data. A predicated instruction writes only in elements whose flag is set, so the controller can process elements selectively according to their content. Execution has two stages: operand fetch, then execute and write-back. A result is forwarded to the instruction that follows it, so dependent instructions can be issued back to back. A read-back port lets the controller fetch any single word from any element.

Top module: `simd_line_array`

## Requirements
- R1: When use-scalar is 0, op 0 writes line i + line j, op 1 writes line i − line j, op 2 writes the low 16 bits of line i × line j, and op 3 writes line i XOR line j. Each result goes to line k of every element, and add and subtract wrap modulo 2^16.
- R2: When use-scalar is 1, ops 0–3 take the scalar input in place of line j, and every element uses the same scalar.
- R3: Op 9 writes the element's own index plus the scalar into line k, modulo 2^16.
- R4: Ops 4, 5, 6 and 7 write no line. They set each element's flag to one of four tests: op 4 is (line i == second operand), op 5 is (line i != second operand), op 6 is a signed line i < second operand, and op 7 is (line i == 0). The second operand is line j or the scalar, chosen by use-scalar. The predicate bit has no effect on these ops.
- R5: When the predicate bit is 1, ops 0–3 and 9 write line k only in elements whose flag is set, and every other element keeps its old value. When the predicate bit is 0, every element is written.
- R6: Op 8 sets the flag of every element. Reset also leaves every flag set.
- R7: An instruction accepted in the cycle after another instruction reads the value that the earlier instruction writes, including on the line it has just written.
- R8: A read-back request (rd_en with a lane and a line) returns the word in the next cycle, with rd_valid high. The word reflects every instruction accepted at least two cycles before the request. While rd_en is low, rd_valid is low and rd_data holds its value.
- R9: in_ready rises in the first cycle after reset is released and then stays high. One instruction is accepted in each cycle in which in_valid and in_ready are both high.
- R10: Ops 10–15 change no line and no flag.
- R11: While reset is held, rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Array can accept an instruction |
| in_op | input | 4 | Opcode |
| in_use_scalar | input | 1 | Use the scalar in place of line j |
| in_pred | input | 1 | Write only in elements whose flag is set |
| in_addr_i | input | ADDR_W | First source line |
| in_addr_j | input | ADDR_W | Second source line |
| in_addr_k | input | ADDR_W | Destination line |
| in_scalar | input | WORD_W | Broadcast scalar |
| rd_en | input | 1 | Read-back request |
| rd_lane | input | log2(N_PE) | Element to read |
| rd_line | input | ADDR_W | Line to read |
| rd_valid | output | 1 | Read-back word present |
| rd_data | output | WORD_W | Read-back word |

## Verification
The assertions assume three things about the inputs. Reset is held for at least two clock cycles. in_valid is low while reset is active. Instructions are offered only while in_ready is high. The flag-source and set-all checks look two cycles back, so they rely on the first two assumptions. The bench always drives in_valid low during reset and waits for in_ready before it issues an instruction. It issues a read-back only after at least one idle cycle following its last instruction, so every word it reads already contains all earlier writes.

// File: rtl/simd_pkg.sv
package simd_pkg;

   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_SUB    = 4'd1,
      OP_MUL    = 4'd2,
      OP_XOR    = 4'd3,
      OP_CEQ    = 4'd4,
      OP_CNE    = 4'd5,
      OP_CLT    = 4'd6,
      OP_CZR    = 4'd7,
      OP_SETALL = 4'd8,
      OP_IOTA   = 4'd9
   } op_e;

   function automatic logic op_writes_line(input logic [3:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
             (op == OP_XOR) || (op == OP_IOTA);
   endfunction

   function automatic logic op_is_compare(input logic [3:0] op);
      return (op == OP_CEQ) || (op == OP_CNE) || (op == OP_CLT) || (op == OP_CZR);
   endfunction

endpackage

// File: rtl/simd_issue.sv
module simd_issue #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic [3:0]        in_op,
   input  logic              in_use_s,
   input  logic              in_pred,
   input  logic [ADDR_W-1:0] in_k,
   input  logic [WORD_W-1:0] in_s,
   output logic              ready,
   output logic              s1_valid,
   output logic [3:0]        s1_op,
   output logic              s1_use_s,
   output logic              s1_pred,
   output logic [ADDR_W-1:0] s1_k,
   output logic [WORD_W-1:0] s1_s
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready    <= 1'b0;
         s1_valid <= 1'b0;
         s1_op    <= '0;
         s1_use_s <= 1'b0;
         s1_pred  <= 1'b0;
         s1_k     <= '0;
         s1_s     <= '0;
      end else begin
         ready    <= 1'b1;
         s1_valid <= acc;
         if (acc) begin
            s1_op    <= in_op;
            s1_use_s <= in_use_s;
            s1_pred  <= in_pred;
            s1_k     <= in_k;
            s1_s     <= in_s;
         end
      end
   end

endmodule

// File: rtl/simd_pe.sv
module simd_pe
   import simd_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6,
   parameter int LANE   = 0,
   localparam int LINES = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic [ADDR_W-1:0] rd_i,
   input  logic [ADDR_W-1:0] rd_j,
   input  logic              s1_valid,
   input  logic [3:0]        s1_op,
   input  logic              s1_use_s,
   input  logic              s1_pred,
   input  logic [ADDR_W-1:0] s1_k,
   input  logic [WORD_W-1:0] s1_s,
   input  logic [ADDR_W-1:0] peek_line,
   output logic              flag,
   output logic              wen,
   output logic [WORD_W-1:0] peek_data
);

   logic [WORD_W-1:0] mem [LINES];
   logic [WORD_W-1:0] opa, opb, b_eff, res;
   logic              cond;

   always_comb b_eff = s1_use_s ? s1_s : opb;

   always_comb begin
      res = opa;
      unique case (s1_op)
         OP_ADD:  res = opa + b_eff;
         OP_SUB:  res = opa - b_eff;
         OP_MUL:  res = opa * b_eff;
         OP_XOR:  res = opa ^ b_eff;
         OP_IOTA: res = WORD_W'(LANE) + s1_s;
         default: res = opa;
      endcase
   end

   always_comb begin
      cond = 1'b0;
      unique case (s1_op)
         OP_CEQ:  cond = (opa == b_eff);
         OP_CNE:  cond = (opa != b_eff);
         OP_CLT:  cond = ($signed(opa) < $signed(b_eff));
         OP_CZR:  cond = (opa == '0);
         default: cond = 1'b0;
      endcase
   end

   always_comb wen = s1_valid && op_writes_line(s1_op) && (!s1_pred || flag);

   always_ff @(posedge clk) begin
      if (wen) mem[s1_k] <= res;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b1;
         opa  <= '0;
         opb  <= '0;
      end else begin
         if (s1_valid && op_is_compare(s1_op)) flag <= cond;
         else if (s1_valid && (s1_op == OP_SETALL)) flag <= 1'b1;
         if (acc) begin
            opa <= (wen && (s1_k == rd_i)) ? res : mem[rd_i];
            opb <= (wen && (s1_k == rd_j)) ? res : mem[rd_j];
         end
      end
   end

   always_comb peek_data = mem[peek_line];

endmodule

// File: rtl/simd_line_array.sv
module simd_line_array
   import simd_pkg::*;
#(
   parameter int N_PE   = 8,
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6,
   localparam int LANE_W = $clog2(N_PE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [3:0]        in_op,
   input  logic              in_use_scalar,
   input  logic              in_pred,
   input  logic [ADDR_W-1:0] in_addr_i,
   input  logic [ADDR_W-1:0] in_addr_j,
   input  logic [ADDR_W-1:0] in_addr_k,
   input  logic [WORD_W-1:0] in_scalar,
   input  logic              rd_en,
   input  logic [LANE_W-1:0] rd_lane,
   input  logic [ADDR_W-1:0] rd_line,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data
);

   if ((N_PE < 2) || ((N_PE & (N_PE - 1)) != 0)) begin : g_bad_npe
      $error("N_PE must be a power of two, at least 2");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if ((ADDR_W < 1) || (ADDR_W > 10)) begin : g_bad_addr
      $error("ADDR_W must lie in 1..10");
   end

   logic              acc, s1_valid, s1_use_s, s1_pred;
   logic [3:0]        s1_op;
   logic [ADDR_W-1:0] s1_k;
   logic [WORD_W-1:0] s1_s;
   logic [N_PE-1:0]   flag_vec, wen_vec;
   logic [WORD_W-1:0] peek_vec [N_PE];
   logic              rd_valid_q;
   logic [WORD_W-1:0] rd_data_q;

   assign acc = in_valid && in_ready;

   simd_issue #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .acc(acc),
      .in_op(in_op), .in_use_s(in_use_scalar), .in_pred(in_pred),
      .in_k(in_addr_k), .in_s(in_scalar),
      .ready(in_ready), .s1_valid(s1_valid), .s1_op(s1_op),
      .s1_use_s(s1_use_s), .s1_pred(s1_pred), .s1_k(s1_k), .s1_s(s1_s)
   );

   for (genvar g = 0; g < N_PE; g++) begin : g_pe
      simd_pe #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LANE(g)) u_pe (
         .clk(clk), .rst_n(rst_n), .acc(acc),
         .rd_i(in_addr_i), .rd_j(in_addr_j),
         .s1_valid(s1_valid), .s1_op(s1_op), .s1_use_s(s1_use_s),
         .s1_pred(s1_pred), .s1_k(s1_k), .s1_s(s1_s),
         .peek_line(rd_line),
         .flag(flag_vec[g]), .wen(wen_vec[g]), .peek_data(peek_vec[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= rd_en;
         if (rd_en) rd_data_q <= peek_vec[rd_lane];
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;

endmodule

// File: rtl/simd_line_array_chk.sv
module simd_line_array_chk
   import simd_pkg::*;
#(
   parameter int N_PE   = 8,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [3:0]        in_op,
   input logic              rd_en,
   input logic              rd_valid,
   input logic [WORD_W-1:0] rd_data,
   input logic [N_PE-1:0]   flags,
   input logic [N_PE-1:0]   wen
);

   assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   assert_rd_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!rd_valid && $stable(rd_data)));

   assert_ready_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> in_ready);

   assert_write_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wen != '0) |-> $past(in_valid && in_ready && op_writes_line(in_op)));

   assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags != $past(flags)) |->
         $past(in_valid && in_ready && (op_is_compare(in_op) || (in_op == OP_SETALL)), 2));

   assert_setall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_ready && (in_op == OP_SETALL), 2) |-> (&flags));

   always_comb begin
      if (!rst_n) assert_reset_quiet_R11: assert (!rd_valid || $isunknown(rd_valid));
   end

endmodule

bind simd_line_array simd_line_array_chk #(.N_PE(N_PE), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_op(in_op), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
   .flags(flag_vec), .wen(wen_vec)
);

// File: tb/simd_line_array_test.sv
`timescale 1ns/1ps
module simd_line_array_test;

   localparam int N  = 8;
   localparam int LN = 64;

   typedef struct packed {
      logic [3:0]  op;
      logic        us;
      logic        pr;
      logic [5:0]  i;
      logic [5:0]  j;
      logic [5:0]  k;
      logic [15:0] s;
   } vec_t;

   // op, use-scalar, pred, i, j, k, scalar
   localparam vec_t TABLE [16] = '{
      '{4'd9, 1'b0, 1'b0, 6'd0, 6'd0, 6'd1, 16'h0000},  // R3 index
      '{4'd9, 1'b0, 1'b0, 6'd0, 6'd0, 6'd2, 16'hFFFA},  // R3 wrap
      '{4'd0, 1'b0, 1'b0, 6'd1, 6'd2, 6'd3, 16'h0000},  // R1 add
      '{4'd1, 1'b0, 1'b0, 6'd1, 6'd2, 6'd4, 16'h0000},  // R1 sub
      '{4'd2, 1'b0, 1'b0, 6'd2, 6'd2, 6'd5, 16'h0000},  // R1 mul
      '{4'd3, 1'b0, 1'b0, 6'd1, 6'd2, 6'd6, 16'h0000},  // R1 xor
      '{4'd0, 1'b1, 1'b0, 6'd2, 6'd0, 6'd7, 16'h0010},  // R2 add scalar
      '{4'd2, 1'b1, 1'b0, 6'd1, 6'd0, 6'd8, 16'h9001},  // R2 mul scalar
      '{4'd1, 1'b1, 1'b0, 6'd1, 6'd0, 6'd9, 16'h0003},  // R2 sub scalar
      '{4'd6, 1'b1, 1'b1, 6'd2, 6'd0, 6'd3, 16'h0000},  // R4 signed lt
      '{4'd0, 1'b1, 1'b1, 6'd1, 6'd0, 6'd3, 16'h0100},  // R5 predicated
      '{4'd4, 1'b1, 1'b0, 6'd1, 6'd0, 6'd4, 16'h0002},  // R4 equal
      '{4'd3, 1'b1, 1'b1, 6'd1, 6'd0, 6'd4, 16'hFFFF},  // R5 predicated
      '{4'd8, 1'b0, 1'b0, 6'd0, 6'd0, 6'd4, 16'h0000},  // R6 set all
      '{4'd0, 1'b0, 1'b1, 6'd1, 6'd1, 6'd4, 16'h0000},  // R6 all active
      '{4'd12, 1'b0, 1'b0, 6'd1, 6'd1, 6'd1, 16'h5555}  // R10 reserved
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_op = '0;
   logic        in_use_scalar = 1'b0;
   logic        in_pred = 1'b0;
   logic [5:0]  in_addr_i = '0, in_addr_j = '0, in_addr_k = '0;
   logic [15:0] in_scalar = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_lane = '0;
   logic [5:0]  rd_line = '0;
   logic        rd_valid;
   logic [15:0] rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [15:0] m [N][LN];
   bit          f [N];

   simd_line_array uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_use_scalar(in_use_scalar), .in_pred(in_pred),
      .in_addr_i(in_addr_i), .in_addr_j(in_addr_j), .in_addr_k(in_addr_k),
      .in_scalar(in_scalar), .rd_en(rd_en), .rd_lane(rd_lane), .rd_line(rd_line),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [3:0] op, input logic us, input logic pr,
                        input logic [5:0] i, input logic [5:0] j, input logic [5:0] k,
                        input logic [15:0] s);
      for (int l = 0; l < N; l++) begin
         logic [15:0] a, b, r;
         bit wr;
         a  = m[l][i];
         b  = us ? s : m[l][j];
         wr = 1;
         r  = '0;
         case (op)
            4'd0: r = a + b;
            4'd1: r = a - b;
            4'd2: r = a * b;
            4'd3: r = a ^ b;
            4'd9: r = 16'(l) + s;
            4'd4: begin f[l] = (a == b); wr = 0; end
            4'd5: begin f[l] = (a != b); wr = 0; end
            4'd6: begin f[l] = ($signed(a) < $signed(b)); wr = 0; end
            4'd7: begin f[l] = (a == 16'd0); wr = 0; end
            4'd8: begin f[l] = 1; wr = 0; end
            default: wr = 0;
         endcase
         if (wr && (!pr || f[l])) m[l][k] = r;
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic us, input logic pr,
                        input logic [5:0] i, input logic [5:0] j, input logic [5:0] k,
                        input logic [15:0] s);
      in_op = op; in_use_scalar = us; in_pred = pr;
      in_addr_i = i; in_addr_j = j; in_addr_k = k; in_scalar = s;
      in_valid = 1'b1;
      @(negedge clk);
      model(op, us, pr, i, j, k, s);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic peek(input int lane, input int line, output logic [15:0] d);
      rd_en = 1'b1; rd_lane = 3'(lane); rd_line = 6'(line);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic check_line(input string tag, input int line);
      logic [15:0] d;
      idle(2);
      for (int l = 0; l < N; l++) begin
         peek(l, line, d);
         chk($sformatf("%s lane %0d line %0d", tag, l, line), d, m[l][line]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d, held;
      for (int l = 0; l < N; l++) f[l] = 1;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 rd_valid in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ready after reset", in_ready, 1);

      // clear every line: index, then subtract from itself
      for (int k = 0; k < LN; k++) begin
         issue(4'd9, 0, 0, 0, 0, 6'(k), 16'h0);
         issue(4'd1, 0, 0, 6'(k), 6'(k), 6'(k), 16'h0);
      end
      check_line("R1 clear", 0);
      check_line("R1 clear", 63);

      // table walk
      for (int t = 0; t < 16; t++) begin
         issue(TABLE[t].op, TABLE[t].us, TABLE[t].pr, TABLE[t].i, TABLE[t].j,
               TABLE[t].k, TABLE[t].s);
         check_line($sformatf("R1/R2/R3/R4/R5/R6/R10 row %0d", t), int'(TABLE[t].k));
      end
      check_line("R10 reserved op", 1);

      // R7: back-to-back dependent chain with forwarding
      issue(4'd9, 0, 0, 0, 0, 6'd20, 16'd5);
      issue(4'd0, 0, 0, 6'd20, 6'd20, 6'd21, 16'd0);
      issue(4'd0, 1, 0, 6'd21, 6'd0, 6'd21, 16'd1);
      idle(2);
      for (int l = 0; l < N; l++) begin
         peek(l, 21, d);
         chk($sformatf("R7 forward lane %0d", l), d, 16'(2 * l + 11));
      end

      // R4: zero test then predicated write, compare ignores pred bit
      issue(4'd7, 0, 1, 6'd1, 6'd0, 6'd0, 16'd0);
      issue(4'd9, 0, 1, 0, 0, 6'd22, 16'h0A00);
      check_line("R4 zero test", 22);
      for (int l = 0; l < N; l++)
         chk($sformatf("R5 unchanged lane %0d", l), m[l][22], (l == 0) ? 16'h0A00 : 16'h0);

      // R8: read valid timing and hold while idle
      peek(3, 21, held);
      chk("R8 rd_valid after request", rd_valid, 1);
      issue(4'd9, 0, 0, 0, 0, 6'd21, 16'h7777);
      idle(2);
      chk("R8 rd_valid low when idle", rd_valid, 0);
      chk("R8 rd_data held", rd_data, held);
      check_line("R8 refreshed", 21);

      // random sequences
      for (int b = 0; b < 15; b++) begin
         for (int n = 0; n < 20; n++)
            issue(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 6'($urandom_range(0, 15)),
                  6'($urandom_range(0, 15)), 6'($urandom_range(0, 15)),
                  16'($urandom));
         for (int k = 0; k < 16; k++) check_line("R1/R2/R5/R7 random", k);
      end

      // R6: reset sets every flag again
      issue(4'd4, 1, 0, 6'd0, 6'd0, 6'd0, 16'hBEEF);
      idle(2);
      rst_n = 1'b0;
      for (int l = 0; l < N; l++) f[l] = 1;
      repeat (2) @(negedge clk);
      chk("R11 rd_valid in reset", rd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ready after second reset", in_ready, 1);
      issue(4'd9, 0, 1, 0, 0, 6'd30, 16'h0077);
      check_line("R6 flags set by reset", 30);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule